// File: doc/BRIEF.md
# Half-Duplex Transmit Status Tracker

This block follows a single outgoing frame on a half-duplex Ethernet MAC, from the moment the frame is handed to the transmitter until it either leaves successfully or is given up. It waits out carrier from other stations, times each transmission attempt in byte strobes, and counts collisions across attempts. It also watches for a transmit buffer underrun. Each collision inside the collision window produces a retry request. A late collision, too many collisions, too long a wait or an underrun ends the frame with an abort.

When the frame ends, the block produces a 10-bit status word with a one-cycle valid strobe, ready to be written back into a transmit descriptor. It then returns to idle and clears all its counters and flags for the next frame. Backoff timing, the data path and descriptor movement are handled elsewhere. After a retry, the block simply waits for carrier to drop again.

In full-duplex mode, collision, carrier and deferral supervision are off, and only the underrun flag can appear.

Top module: `hd_tx_status`

## Requirements
- R1: After reset, `stat_valid`, `retry`, `abort` and `stat_word` are all zero.
- R2: `stat_word` bit 0 is underrun, bit 1 late collision, bit 2 excessive collisions, bit 3 excessive deferral, bit 4 no carrier, bit 5 deferred, and bits 9:6 the collision count. One cycle after `tx_end` is sampled during transmission, `stat_valid` pulses for exactly one cycle with `abort` low. Every abort is reported with `stat_valid` in the same cycle.
- R3: A half-duplex collision seen before 64 byte strobes of the current attempt pulses `retry` one cycle later, adds one to the collision count, and sends the block back to deferral.
- R4: A collision seen after 64 or more byte strobes of the current attempt ends the frame one cycle later with `abort`, bit 1 set, and the collision count left unchanged.
- R5: The 16th collision on one frame ends it with `abort` and bit 2 set, with no retry. The count field then reads 15.
- R6: With `retry_dis` high, the first collision ends the frame with `abort` and bit 2 set (count 1), and no `retry` pulse is produced.
- R7: With `defer_chk_en` high, the 3037th byte strobe spent deferring (more than 24288 bit times) ends the frame with `abort` and bit 3 set. With `defer_chk_en` low, deferral never times out.
- R8: Bit 4 is set at a successful end if `crs` was never high during the final transmission attempt.
- R9: `underflow` during transmission aborts the frame with bit 0 set. A collision in the same cycle is ignored, so bit 1 is never set together with bit 0.
- R10: Bit 5 is set when carrier was seen while deferring before the first attempt.
- R11: In full-duplex mode, collisions and carrier are ignored. Only bit 0 can be set, and `retry` never pulses.
- R12: The attempt byte counter saturates rather than wraps, so a collision after 300 byte strobes is still late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 = full-duplex mode |
| retry_dis | input | 1 | Abort on the first collision |
| defer_chk_en | input | 1 | Enables the deferral timeout |
| frame_start | input | 1 | Pulse: a new frame is ready (accepted when idle) |
| crs | input | 1 | Carrier sense from the PHY |
| col | input | 1 | Collision from the PHY |
| byte_tick | input | 1 | One pulse per byte time |
| underflow | input | 1 | Transmit data arrived late |
| tx_end | input | 1 | Pulse: last byte of the frame sent |
| stat_valid | output | 1 | One-cycle strobe: `stat_word` is final |
| stat_word | output | 10 | Final transmit status (fields in R2) |
| retry | output | 1 | One-cycle retry request after a collision |
| abort | output | 1 | One-cycle strobe: the frame was given up |

## Verification
Every result is registered once, so `stat_valid`, `stat_word`, `abort` and `retry` appear one clock after the edge that samples the causing input. The cause can be `tx_end`, `col`, `underflow` or the byte strobe that crosses the deferral limit. The bench changes inputs on falling edges and samples outputs on falling edges. A result is therefore expected at the first falling edge after the sampling rising edge. The driver queues each expected status word before that edge. The monitor flags any strobe that arrives with an empty queue, which catches results that come early or without cause.

// File: rtl/hd_txs_pkg.sv
package hd_txs_pkg;

  localparam int CC_W      = 4;
  localparam int COL_LIMIT = 1 << CC_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEFER = 2'd1,
    ST_XMIT  = 2'd2
  } txs_state_t;

  typedef struct packed {
    logic [CC_W-1:0] ncol;
    logic            deferred;
    logic            no_carrier;
    logic            defer_to;
    logic            excess;
    logic            late;
    logic            underrun;
  } txs_word_t;

  function automatic logic [CC_W-1:0] f_cc_bump(input logic [CC_W-1:0] c);
    return (c == {CC_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  function automatic int f_defer_bytes(input int bits);
    return bits / 8;
  endfunction

endpackage

// File: rtl/hd_txs_satcnt.sv
module hd_txs_satcnt #(
  parameter int MAX = 15,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  localparam logic [W-1:0] MAXV = W'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (inc && cnt != MAXV)   cnt <= cnt + 1'b1;
  end

  assign at_max = (cnt == MAXV);
endmodule

// File: rtl/hd_tx_status.sv
module hd_tx_status
  import hd_txs_pkg::*;
#(
  parameter int LATE_BYTES       = 64,
  parameter int DEFER_LIMIT_BITS = 24288
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_duplex,
  input  logic       retry_dis,
  input  logic       defer_chk_en,
  input  logic       frame_start,
  input  logic       crs,
  input  logic       col,
  input  logic       byte_tick,
  input  logic       underflow,
  input  logic       tx_end,
  output logic       stat_valid,
  output logic [9:0] stat_word,
  output logic       retry,
  output logic       abort
);
  localparam int DEFER_BYTES = f_defer_bytes(DEFER_LIMIT_BITS);
  localparam int BC_W        = $clog2(LATE_BYTES + 1);
  localparam int DC_W        = $clog2(DEFER_BYTES + 1);

  txs_state_t state;
  logic hd, in_idle, in_defer, in_xmit;
  logic carrier_seen, deferred_q;

  logic [BC_W-1:0] byte_cnt;
  logic [DC_W-1:0] defer_cnt;
  logic [CC_W-1:0] col_cnt;
  logic byte_at_max, defer_at_max, col_at_max;

  // named internal events (also observed by the checker)
  logic ev_defer_to, ev_defer_go, ev_uf, ev_col, ev_late;
  logic ev_excess, ev_retry, ev_done, ev_finish;
  txs_word_t w_next;

  assign hd       = !full_duplex;
  assign in_idle  = (state == ST_IDLE);
  assign in_defer = (state == ST_DEFER);
  assign in_xmit  = (state == ST_XMIT);

  assign ev_defer_to = in_defer && hd && defer_chk_en && byte_tick && defer_at_max;
  assign ev_defer_go = in_defer && !ev_defer_to && !crs;
  assign ev_uf       = in_xmit && underflow;
  assign ev_col      = in_xmit && hd && col && !underflow;
  assign ev_late     = ev_col && byte_at_max;
  assign ev_excess   = ev_col && !byte_at_max && (retry_dis || col_at_max);
  assign ev_retry    = ev_col && !byte_at_max && !retry_dis && !col_at_max;
  assign ev_done     = in_xmit && tx_end && !underflow && !(hd && col);
  assign ev_finish   = ev_defer_to || ev_uf || ev_late || ev_excess || ev_done;

  hd_txs_satcnt #(.MAX(LATE_BYTES)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clr(!in_xmit), .inc(in_xmit && byte_tick),
    .cnt(byte_cnt), .at_max(byte_at_max));

  hd_txs_satcnt #(.MAX(DEFER_BYTES)) u_defer (
    .clk(clk), .rst_n(rst_n), .clr(in_idle), .inc(in_defer && byte_tick),
    .cnt(defer_cnt), .at_max(defer_at_max));

  hd_txs_satcnt #(.MAX(COL_LIMIT - 1)) u_cols (
    .clk(clk), .rst_n(rst_n), .clr(in_idle), .inc(ev_retry || ev_excess),
    .cnt(col_cnt), .at_max(col_at_max));

  always_comb begin
    w_next            = '0;
    w_next.underrun   = ev_uf;
    w_next.late       = ev_late;
    w_next.excess     = ev_excess;
    w_next.defer_to   = ev_defer_to;
    w_next.no_carrier = ev_done && hd && !(carrier_seen || crs);
    w_next.deferred   = hd && (deferred_q || (in_defer && crs && col_cnt == '0));
    w_next.ncol       = (ev_retry || ev_excess) ? f_cc_bump(col_cnt) : col_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || in_idle) begin
      carrier_seen <= 1'b0;
      deferred_q   <= 1'b0;
    end else begin
      if (in_xmit && crs) carrier_seen <= 1'b1;
      if (ev_retry)       carrier_seen <= 1'b0;
      if (in_defer && hd && crs && col_cnt == '0) deferred_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      stat_valid <= 1'b0;
      stat_word  <= '0;
      retry      <= 1'b0;
      abort      <= 1'b0;
    end else begin
      stat_valid <= ev_finish;
      retry      <= ev_retry;
      abort      <= ev_finish && !ev_done;
      if (ev_finish) stat_word <= w_next;
      unique case (state)
        ST_IDLE:  if (frame_start) state <= hd ? ST_DEFER : ST_XMIT;
        ST_DEFER: if (ev_defer_to) state <= ST_IDLE;
                  else if (ev_defer_go) state <= ST_XMIT;
        ST_XMIT:  if (ev_finish) state <= ST_IDLE;
                  else if (ev_retry) state <= ST_DEFER;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hd_txs_chk.sv
module hd_txs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       full_duplex,
  input logic       retry_dis,
  input logic       stat_valid,
  input logic [9:0] stat_word,
  input logic       retry,
  input logic       abort,
  input logic       ev_late,
  input logic       ev_excess
);
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);
  p_abort_has_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> stat_valid);
  p_retry_not_final_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry && stat_valid));
  p_late_reported_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_late |=> (stat_valid && abort && stat_word[1]));
  p_excess_reported_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_excess |=> (stat_valid && abort && stat_word[2]));
  p_no_retry_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !$past(retry_dis));
  p_late_uf_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !(stat_word[1] && stat_word[0]));
  p_fd_only_uf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && $past(full_duplex)) |-> (stat_word[9:1] == 9'd0));
endmodule

bind hd_tx_status hd_txs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .retry_dis(retry_dis),
  .stat_valid(stat_valid), .stat_word(stat_word), .retry(retry), .abort(abort),
  .ev_late(ev_late), .ev_excess(ev_excess));

// File: tb/hd_tx_status_test.sv
`timescale 1ns/1ps
module hd_tx_status_test;
  logic clk = 1'b0;
  logic rst_n, full_duplex, retry_dis, defer_chk_en, frame_start;
  logic crs, col, byte_tick, underflow, tx_end;
  logic stat_valid, retry, abort;
  logic [9:0] stat_word;

  int n_checks = 0, n_errors = 0, n_retry = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  hd_tx_status uut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .retry_dis(retry_dis),
    .defer_chk_en(defer_chk_en), .frame_start(frame_start), .crs(crs), .col(col),
    .byte_tick(byte_tick), .underflow(underflow), .tx_end(tx_end),
    .stat_valid(stat_valid), .stat_word(stat_word), .retry(retry), .abort(abort));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_stat(input string req, input logic ab, input logic [9:0] w);
    exp_q.push_back({ab, w});
    tag_q.push_back(req);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (retry) n_retry++;
      if (stat_valid) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected status", {21'd0, abort, stat_word}, 0);
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {21'd0, abort, stat_word}, {21'd0, e});
        end
      end
    end
  end

  task automatic begin_frame(input logic carrier);
    @(negedge clk); frame_start = 1'b1; crs = carrier;
    @(negedge clk); frame_start = 1'b0;
  endtask
  task automatic to_xmit;
    crs = 1'b0; @(negedge clk); crs = 1'b1;
  endtask
  task automatic bytes(input int n);
    byte_tick = 1'b1; repeat (n) @(negedge clk); byte_tick = 1'b0;
  endtask
  task automatic collide;
    @(negedge clk); col = 1'b1;
    @(negedge clk); col = 1'b0;
  endtask
  task automatic finish_ok;
    @(negedge clk); tx_end = 1'b1;
    @(negedge clk); tx_end = 1'b0;
  endtask
  task automatic settle;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 0; full_duplex = 0; retry_dis = 0; defer_chk_en = 0; frame_start = 0;
    crs = 0; col = 0; byte_tick = 0; underflow = 0; tx_end = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", stat_valid, 0);
    chk("R1 word", stat_word, 0);
    chk("R1 retry/abort", {retry, abort}, 0);

    // R2 clean frame
    begin_frame(1'b0); to_xmit(); bytes(80);
    expect_stat("R2 clean frame", 1'b0, 10'h000);
    finish_ok(); settle();

    // R3 collision at 63 bytes -> retry, then success with count 1
    base = n_retry;
    begin_frame(1'b0); to_xmit(); bytes(63);
    collide(); to_xmit(); bytes(10);
    expect_stat("R3 count after retry", 1'b0, 10'h040);
    finish_ok(); settle();
    chk("R3 retry pulses", n_retry - base, 1);

    // R4 collision at 64 bytes -> late
    begin_frame(1'b0); to_xmit(); bytes(64);
    expect_stat("R4 late collision", 1'b1, 10'h002);
    collide(); settle();

    // R12 byte counter saturates, 300 bytes still late
    begin_frame(1'b0); to_xmit(); bytes(300);
    expect_stat("R12 no wrap", 1'b1, 10'h002);
    collide(); settle();

    // R5 sixteen collisions
    base = n_retry;
    begin_frame(1'b0); to_xmit();
    for (int i = 0; i < 15; i++) begin
      bytes(2); collide(); to_xmit();
    end
    expect_stat("R5 excessive", 1'b1, 10'h3C4);
    collide(); settle();
    chk("R5 retries", n_retry - base, 15);

    // R6 retry disabled
    base = n_retry;
    retry_dis = 1'b1;
    begin_frame(1'b0); to_xmit();
    expect_stat("R6 first collision", 1'b1, 10'h044);
    collide(); settle();
    chk("R6 no retry", n_retry - base, 0);
    retry_dis = 1'b0;

    // R7 deferral timeout: 3036 strobes fine, 3037th ends
    defer_chk_en = 1'b1;
    begin_frame(1'b1);
    byte_tick = 1'b1;
    repeat (3036) @(negedge clk);
    expect_stat("R7 excessive deferral", 1'b1, 10'h028);
    @(negedge clk); byte_tick = 1'b0;
    settle();
    // R7 disabled: long deferral, no timeout
    defer_chk_en = 1'b0;
    begin_frame(1'b1); bytes(3100);
    to_xmit();
    expect_stat("R7 no timeout when off / R10 deferred", 1'b0, 10'h020);
    finish_ok(); settle();

    // R8 no carrier
    begin_frame(1'b0); crs = 1'b0; @(negedge clk); bytes(20);
    expect_stat("R8 no carrier", 1'b0, 10'h010);
    finish_ok(); settle();

    // R9 underflow with simultaneous late collision
    begin_frame(1'b0); to_xmit(); bytes(70);
    expect_stat("R9 underflow wins", 1'b1, 10'h001);
    @(negedge clk); underflow = 1'b1; col = 1'b1;
    @(negedge clk); underflow = 1'b0; col = 1'b0;
    settle();

    // R10 carrier at start sets deferred
    begin_frame(1'b1); @(negedge clk); @(negedge clk); to_xmit(); bytes(5);
    expect_stat("R10 deferred", 1'b0, 10'h020);
    finish_ok(); settle();

    // R11 full duplex: collision and carrier ignored
    base = n_retry;
    full_duplex = 1'b1;
    begin_frame(1'b0); crs = 1'b0; bytes(10); collide();
    expect_stat("R11 fd clean", 1'b0, 10'h000);
    finish_ok(); settle();
    chk("R11 no retry", n_retry - base, 0);
    begin_frame(1'b0); bytes(4);
    expect_stat("R11 fd underflow", 1'b1, 10'h001);
    @(negedge clk); underflow = 1'b1;
    @(negedge clk); underflow = 1'b0;
    settle();
    full_duplex = 1'b0;

    chk("R2 all expected statuses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule